// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block generates SCL and the condition timing that an I2C master needs. A transaction sequencer asks for one bus phase at a time: a START, a repeated START, a single data bit or a STOP. The block drives the open-drain enables for SCL and SDA through that phase and returns a one-cycle completion pulse. While a data bit's SCL high period is in progress, it also raises a single-cycle strobe that tells the sequencer when to sample SDA.

Every interval is a count of cycles of the 16 MHz core clock. Software sets the SCL high period and the SCL low period separately, each as a 7-bit count. The START hold time, the repeated-START setup time and the STOP setup time are each an 8-bit count. Typical values are 0x0A for fast mode. Standard mode uses 0x47 for the START hold and 0x50 for the repeated-START setup. A zero in either SCL period count stops the bus clock: any phase in progress freezes until both counts are nonzero again.

Top module: `i2c_bus_timer`

## Requirements
- R1: During and after reset, both drive enables are low (lines released), and `busy`, `done` and `sda_sample` are low.
- R2: A request is taken when `req_valid` is high and `busy` is low, with `req_kind` encoded as 0 = START, 1 = repeated START, 2 = data bit, 3 = STOP. A request raised while `busy` is high is ignored and does not alter the phase in progress.
- R3: After a START is accepted, SDA is driven low while SCL stays released for the START hold count. Then SCL is driven low and SDA stays low.
- R4: After a data bit is accepted, SCL is driven low for the low count with SDA driven low exactly when `req_bit` is 0. SCL is then released for the high count with SDA unchanged. Afterwards SCL is driven low and SDA keeps the bit.
- R5: `sda_sample` pulses exactly once in each data-bit high period, in zero-based cycle floor(high/2) of that period, and never while SCL is driven low.
- R6: After a repeated START is accepted, SCL is held low with SDA released for the low count. Both lines are then released for the repeated-START setup count. SDA is then driven low with SCL released for the START hold count. Finally SCL is driven low.
- R7: After a STOP is accepted, both lines are driven low for the low count. SCL is then released while SDA stays low for the STOP setup count. SDA is then released and the block is idle with both lines released.
- R8: `done` is high for exactly one cycle: the first cycle in which the lines show the state that follows the phase. `busy` is low in that cycle.
- R9: While `cfg_scl_high` or `cfg_scl_low` is zero, a phase in progress does not advance. Both lines hold their levels and no `done` or `sda_sample` is produced. The phase resumes once both counts are nonzero.
- R10: A START hold, repeated-START setup or STOP setup count of zero gives an interval of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scl_high | input | 7 | SCL high period in cycles (0 halts the clock) |
| cfg_scl_low | input | 7 | SCL low period in cycles (0 halts the clock) |
| cfg_start_hold | input | 8 | START hold time in cycles |
| cfg_rs_setup | input | 8 | Repeated-START setup time in cycles |
| cfg_stop_setup | input | 8 | STOP setup time in cycles |
| req_valid | input | 1 | Phase request strobe |
| req_kind | input | 2 | Phase kind: 0 START, 1 repeated START, 2 bit, 3 STOP |
| req_bit | input | 1 | Data bit value for a bit phase |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_sample | output | 1 | One-cycle SDA sampling strobe |
| done | output | 1 | One-cycle phase completion pulse |
| busy | output | 1 | A phase is in progress |

## Verification
Each of the sixteen combinations of SCL high and low counts from 1 to 4 is run through a START, a 0 bit, a 1 bit, a repeated START, another bit and a STOP. The condition timings are cycled through 0 to 3 across these runs. Every cycle of every phase is compared against a run-length trace computed from the counts. This separates mistakes in segment order, in off-by-one segment lengths and in the zero-count rule. Odd and even high counts place the sampling strobe at distinct midpoints, so an error in the midpoint arithmetic shows. A STOP request raised in the middle of a bit shows whether a busy request leaks into the phase. One run uses full standard-mode counts. A run with the high count forced to zero checks that a pending bit freezes and then finishes with a single strobe.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;

  typedef enum logic [1:0] {
    REQ_START   = 2'd0,
    REQ_RESTART = 2'd1,
    REQ_BIT     = 2'd2,
    REQ_STOP    = 2'd3
  } req_kind_e;

  typedef enum logic [3:0] {
    PH_IDLE       = 4'd0,
    PH_HELD       = 4'd1,
    PH_START_HOLD = 4'd2,
    PH_BIT_LOW    = 4'd3,
    PH_BIT_HIGH   = 4'd4,
    PH_RS_RELEASE = 4'd5,
    PH_RS_SETUP   = 4'd6,
    PH_STOP_LOW   = 4'd7,
    PH_STOP_SETUP = 4'd8
  } phase_e;

  // Interval length in cycles: a zero count still lasts one cycle.
  function automatic int unsigned seg_len(input int unsigned cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  // Value loaded into the down counter at the start of an interval.
  function automatic int unsigned seg_last(input int unsigned cnt);
    return seg_len(cnt) - 1;
  endfunction

  // Counter value in the high-period cycle floor(len/2).
  function automatic int unsigned mid_remaining(input int unsigned hi_cnt);
    int unsigned len;
    len = seg_len(hi_cnt);
    return (len - 1) - (len / 2);
  endfunction

  function automatic logic clk_is_halted(input int unsigned hi_cnt,
                                         input int unsigned lo_cnt);
    return (hi_cnt == 0) || (lo_cnt == 0);
  endfunction

endpackage

// File: rtl/i2c_tmr_counter.sv
module i2c_tmr_counter #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_last,
  input  logic             halt,
  output logic [TMR_W-1:0] tmr,
  output logic             expire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (load) begin
      tmr <= load_last;
    end else if (!halt && (tmr != '0)) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign expire = (tmr == '0) && !halt;

endmodule

// File: rtl/i2c_tmr_sequencer.sv
module i2c_tmr_sequencer
  import i2c_tmr_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int HOLD_W = 8,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  req_kind_e         req_kind,
  input  logic              req_bit,
  input  logic [CNT_W-1:0]  cfg_scl_high,
  input  logic [CNT_W-1:0]  cfg_scl_low,
  input  logic [HOLD_W-1:0] cfg_start_hold,
  input  logic [HOLD_W-1:0] cfg_rs_setup,
  input  logic [HOLD_W-1:0] cfg_stop_setup,
  input  logic              expire,
  output phase_e            phase,
  output logic              load,
  output logic [TMR_W-1:0]  load_last,
  output logic              bit_q,
  output logic              rest_sda_low,
  output logic              done
);

  phase_e nxt;
  logic   fin;
  logic   accept;

  assign accept = req_valid && ((phase == PH_IDLE) || (phase == PH_HELD));

  always_comb begin
    nxt  = phase;
    load = 1'b0;
    fin  = 1'b0;
    unique case (phase)
      PH_IDLE, PH_HELD: begin
        if (accept) begin
          load = 1'b1;
          unique case (req_kind)
            REQ_START:   nxt = PH_START_HOLD;
            REQ_RESTART: nxt = PH_RS_RELEASE;
            REQ_BIT:     nxt = PH_BIT_LOW;
            default:     nxt = PH_STOP_LOW;
          endcase
        end
      end
      PH_START_HOLD: if (expire) begin nxt = PH_HELD; fin = 1'b1; end
      PH_BIT_LOW:    if (expire) begin nxt = PH_BIT_HIGH; load = 1'b1; end
      PH_BIT_HIGH:   if (expire) begin nxt = PH_HELD; fin = 1'b1; end
      PH_RS_RELEASE: if (expire) begin nxt = PH_RS_SETUP; load = 1'b1; end
      PH_RS_SETUP:   if (expire) begin nxt = PH_START_HOLD; load = 1'b1; end
      PH_STOP_LOW:   if (expire) begin nxt = PH_STOP_SETUP; load = 1'b1; end
      PH_STOP_SETUP: if (expire) begin nxt = PH_IDLE; fin = 1'b1; end
      default:       nxt = PH_IDLE;
    endcase
  end

  // Interval length for the phase being entered.
  always_comb begin
    unique case (nxt)
      PH_START_HOLD: load_last = TMR_W'(seg_last(int'(cfg_start_hold)));
      PH_BIT_HIGH:   load_last = TMR_W'(seg_last(int'(cfg_scl_high)));
      PH_RS_SETUP:   load_last = TMR_W'(seg_last(int'(cfg_rs_setup)));
      PH_STOP_SETUP: load_last = TMR_W'(seg_last(int'(cfg_stop_setup)));
      PH_BIT_LOW, PH_RS_RELEASE, PH_STOP_LOW:
                     load_last = TMR_W'(seg_last(int'(cfg_scl_low)));
      default:       load_last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      bit_q        <= 1'b1;
      rest_sda_low <= 1'b0;
      done         <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= fin;
      if (accept && (req_kind == REQ_BIT)) bit_q <= req_bit;
      if (fin && (phase == PH_START_HOLD)) rest_sda_low <= 1'b1;
      if (fin && (phase == PH_BIT_HIGH))   rest_sda_low <= !bit_q;
    end
  end

endmodule

// File: rtl/i2c_tmr_line_drv.sv
module i2c_tmr_line_drv
  import i2c_tmr_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TMR_W = 8
) (
  input  phase_e           phase,
  input  logic             bit_q,
  input  logic             rest_sda_low,
  input  logic [TMR_W-1:0] tmr,
  input  logic [CNT_W-1:0] cfg_scl_high,
  input  logic             halt,
  output logic             scl_low,
  output logic             sda_low,
  output logic             sample
);

  logic [TMR_W-1:0] mid_val;
  assign mid_val = TMR_W'(mid_remaining(int'(cfg_scl_high)));

  always_comb begin
    unique case (phase)
      PH_HELD, PH_BIT_LOW, PH_RS_RELEASE, PH_STOP_LOW: scl_low = 1'b1;
      default:                                         scl_low = 1'b0;
    endcase
    unique case (phase)
      PH_HELD:                     sda_low = rest_sda_low;
      PH_START_HOLD:               sda_low = 1'b1;
      PH_BIT_LOW, PH_BIT_HIGH:     sda_low = !bit_q;
      PH_STOP_LOW, PH_STOP_SETUP:  sda_low = 1'b1;
      default:                     sda_low = 1'b0;
    endcase
  end

  // Gated by halt so a frozen counter cannot repeat the strobe.
  assign sample = (phase == PH_BIT_HIGH) && (tmr == mid_val) && !halt;

endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
  import i2c_tmr_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_scl_high,
  input  logic [CNT_W-1:0]  cfg_scl_low,
  input  logic [HOLD_W-1:0] cfg_start_hold,
  input  logic [HOLD_W-1:0] cfg_rs_setup,
  input  logic [HOLD_W-1:0] cfg_stop_setup,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_bit,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              sda_sample,
  output logic              done,
  output logic              busy
);

  localparam int TMR_W = (HOLD_W > CNT_W) ? HOLD_W : CNT_W;

  phase_e           phase;
  logic             load;
  logic [TMR_W-1:0] load_last;
  logic [TMR_W-1:0] tmr;
  logic             expire;
  logic             bit_q;
  logic             rest_sda_low;
  logic             clk_halt;

  assign clk_halt = clk_is_halted(int'(cfg_scl_high), int'(cfg_scl_low));
  assign busy     = !((phase == PH_IDLE) || (phase == PH_HELD));

  i2c_tmr_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_last (load_last),
    .halt      (clk_halt),
    .tmr       (tmr),
    .expire    (expire)
  );

  i2c_tmr_sequencer #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .TMR_W(TMR_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_kind       (req_kind_e'(req_kind)),
    .req_bit        (req_bit),
    .cfg_scl_high   (cfg_scl_high),
    .cfg_scl_low    (cfg_scl_low),
    .cfg_start_hold (cfg_start_hold),
    .cfg_rs_setup   (cfg_rs_setup),
    .cfg_stop_setup (cfg_stop_setup),
    .expire         (expire),
    .phase          (phase),
    .load           (load),
    .load_last      (load_last),
    .bit_q          (bit_q),
    .rest_sda_low   (rest_sda_low),
    .done           (done)
  );

  i2c_tmr_line_drv #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_drv (
    .phase        (phase),
    .bit_q        (bit_q),
    .rest_sda_low (rest_sda_low),
    .tmr          (tmr),
    .cfg_scl_high (cfg_scl_high),
    .halt         (clk_halt),
    .scl_low      (scl_drive_low),
    .sda_low      (sda_drive_low),
    .sample       (sda_sample)
  );

endmodule

// File: rtl/i2c_bus_timer_chk.sv
module i2c_bus_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic sda_sample,
  input logic clk_halt
);

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |-> (!scl_drive_low && !sda_drive_low && !busy && !done)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_STROBE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample |-> (!scl_drive_low && busy)); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample |=> !sda_sample); // R5

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_halt && busy) |=> ($stable(scl_drive_low) && $stable(sda_drive_low) && !done)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !scl_drive_low) |-> !sda_drive_low); // R7

endmodule

bind i2c_bus_timer i2c_bus_timer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .sda_sample    (sda_sample),
  .clk_halt      (clk_halt)
);

// File: tb/i2c_bus_timer_tb_top.sv
module i2c_bus_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cfg_scl_high = 7'd2;
  logic [6:0] cfg_scl_low = 7'd2;
  logic [7:0] cfg_start_hold = 8'd1;
  logic [7:0] cfg_rs_setup = 8'd1;
  logic [7:0] cfg_stop_setup = 8'd1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       req_bit = 1'b0;
  logic       scl_drive_low, sda_drive_low, sda_sample, done, busy;

  int n_chk = 0;
  int n_bad = 0;

  int   e_n;
  logic e_scl [4];
  logic e_sda [4];
  int   e_len [4];
  logic e_end_scl, e_end_sda;
  int   e_strobe;
  bit   poke_busy = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_timer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_scl_high   (cfg_scl_high),
    .cfg_scl_low    (cfg_scl_low),
    .cfg_start_hold (cfg_start_hold),
    .cfg_rs_setup   (cfg_rs_setup),
    .cfg_stop_setup (cfg_stop_setup),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .req_bit        (req_bit),
    .scl_drive_low  (scl_drive_low),
    .sda_drive_low  (sda_drive_low),
    .sda_sample     (sda_sample),
    .done           (done),
    .busy           (busy)
  );

  function automatic int ilen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic seg(input int i, input logic s, input logic d, input int l);
    e_scl[i] = s; e_sda[i] = d; e_len[i] = l;
  endtask

  // Codes: 0 START, 1 repeated START, 2 bit, 3 STOP. Lines: 1 = driven low.
  task automatic plan_phase(input int kind, input logic b);
    int lo, hi;
    lo = int'(cfg_scl_low); hi = int'(cfg_scl_high);
    e_strobe = -1;
    case (kind)
      0: begin e_n = 1; seg(0, 1'b0, 1'b1, ilen(int'(cfg_start_hold)));
         e_end_scl = 1'b1; e_end_sda = 1'b1; end
      1: begin e_n = 3; seg(0, 1'b1, 1'b0, lo);
         seg(1, 1'b0, 1'b0, ilen(int'(cfg_rs_setup)));
         seg(2, 1'b0, 1'b1, ilen(int'(cfg_start_hold)));
         e_end_scl = 1'b1; e_end_sda = 1'b1; end
      2: begin e_n = 2; seg(0, 1'b1, !b, lo); seg(1, 1'b0, !b, hi);
         e_end_scl = 1'b1; e_end_sda = !b; e_strobe = lo + hi / 2; end
      default: begin e_n = 2; seg(0, 1'b1, 1'b1, lo);
         seg(1, 1'b0, 1'b1, ilen(int'(cfg_stop_setup)));
         e_end_scl = 1'b0; e_end_sda = 1'b0; end
    endcase
  endtask

  task automatic run_phase(input int kind, input logic b, input string tag);
    int mism, first_act, first_exp, strobes, pos, cyc;
    mism = 0; strobes = 0; pos = -1; cyc = 0; first_act = 0; first_exp = 0;
    plan_phase(kind, b);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_bit = b;
    @(negedge clk);
    for (int i = 0; i < e_n; i++) begin
      for (int j = 0; j < e_len[i]; j++) begin
        if (i > 0 || j > 0) @(negedge clk);
        if (poke_busy && i == 0 && j == 0) begin
          req_valid = 1'b1; req_kind = 2'd3;
        end else begin
          req_valid = 1'b0;
        end
        if (scl_drive_low !== e_scl[i] || sda_drive_low !== e_sda[i] ||
            done !== 1'b0 || busy !== 1'b1) begin
          if (mism == 0) begin
            first_act = {busy, done, scl_drive_low, sda_drive_low};
            first_exp = {2'b10, e_scl[i], e_sda[i]};
          end
          mism++;
        end
        if (sda_sample) begin strobes++; pos = cyc; end
        cyc++;
      end
    end
    chk(mism == 0, tag, "line trace {busy,done,scl,sda} first bad cycle", first_act, first_exp);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && scl_drive_low === e_end_scl &&
        sda_drive_low === e_end_sda, "R8", "done cycle {done,busy,scl,sda}",
        {done, busy, scl_drive_low, sda_drive_low}, {2'b10, e_end_scl, e_end_sda});
    @(negedge clk);
    chk(done === 1'b0 && scl_drive_low === e_end_scl && sda_drive_low === e_end_sda,
        "R8", "cycle after done {done,scl,sda}",
        {done, scl_drive_low, sda_drive_low}, {1'b0, e_end_scl, e_end_sda});
    chk(strobes == ((e_strobe >= 0) ? 1 : 0) && pos == e_strobe, "R5",
        "strobe position", pos, e_strobe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int mism, strobes, seen;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({scl_drive_low, sda_drive_low, busy, done, sda_sample} == 5'b0, "R1",
        "during reset", {scl_drive_low, sda_drive_low, busy, done, sda_sample}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({scl_drive_low, sda_drive_low, busy, done, sda_sample} == 5'b0, "R1",
        "after reset", {scl_drive_low, sda_drive_low, busy, done, sda_sample}, 0);

    // Sweep of SCL counts; condition counts cycle through 0..3 (0 covers R10)
    for (int h = 1; h <= 4; h++) begin
      for (int l = 1; l <= 4; l++) begin
        cfg_scl_high   = 7'(h);
        cfg_scl_low    = 7'(l);
        cfg_start_hold = 8'((h + l) % 4);
        cfg_rs_setup   = 8'((h + 2 * l) % 4);
        cfg_stop_setup = 8'((2 * h + l) % 4);
        run_phase(0, 1'b0, (cfg_start_hold == 0) ? "R3 R10" : "R3");
        run_phase(2, 1'b0, "R4");
        poke_busy = 1'b1;
        run_phase(2, 1'b1, "R2 R4");
        poke_busy = 1'b0;
        run_phase(1, 1'b0, "R6");
        run_phase(2, 1'(h + l), "R4");
        run_phase(3, 1'b0, (cfg_stop_setup == 0) ? "R7 R10" : "R7");
      end
    end

    // Standard-mode style counts
    cfg_scl_high = 7'd80; cfg_scl_low = 7'd79;
    cfg_start_hold = 8'h47; cfg_rs_setup = 8'h50; cfg_stop_setup = 8'h50;
    run_phase(0, 1'b0, "R3");
    run_phase(2, 1'b1, "R4");
    run_phase(1, 1'b0, "R6");
    run_phase(2, 1'b0, "R4");
    run_phase(3, 1'b0, "R7");

    // R9 halted clock freezes a pending bit
    cfg_scl_high = 7'd2; cfg_scl_low = 7'd3;
    cfg_start_hold = 8'd2; cfg_rs_setup = 8'd2; cfg_stop_setup = 8'd2;
    run_phase(0, 1'b0, "R3");
    cfg_scl_high = 7'd0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2; req_bit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    mism = 0;
    for (int k = 0; k < 40; k++) begin
      if (scl_drive_low !== 1'b1 || sda_drive_low !== 1'b1 || done !== 1'b0 ||
          sda_sample !== 1'b0) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R9", "cycles changed while halted", mism, 0);
    cfg_scl_high = 7'd2;
    strobes = 0; seen = 0;
    for (int k = 0; k < 20 && seen == 0; k++) begin
      @(negedge clk);
      if (sda_sample) strobes++;
      if (done) seen = 1;
    end
    chk(seen == 1, "R9", "done after resume", seen, 1);
    chk(strobes == 1, "R9", "strobes after resume", strobes, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule